// File: doc/BRIEF.md
# Per-Core Interval Tick Timer

This block is a single local timer channel meant to serve one processor core. Software configures it over a simple 32-bit register write/read port. Two counters are cascaded. A prescaler turns the input clock into ticks: each tick lasts the programmed tick length plus one clock. An interrupt counter then counts those ticks down from a programmed reload value. When it expires, it sets an interrupt status flag, and that flag reaches the interrupt output only while the interrupt enable is set.

In repeat mode, the interrupt counter reloads on every expiry and keeps firing at a fixed period until software clears its start bits. Without repeat mode, it fires once and then halts until software restarts it. The three buffered registers are the tick length, the reload value and the control word. A write to any of them takes effect two clock edges after it is presented. In that same edge it raises its own bit in a write-done register, which software clears by writing 1.

Top module: `tick_timer_channel`

## Requirements
- R1: After reset every register reads 0 and `irqOut` is low.
- R2: A write to the tick length (offset 0x00), reload (0x08) or control (0x20) register is visible on readback, and acts on the counters, after the second rising edge counting the edge that samples the write; after the first edge the old value still reads back.
- R3: Write-done register (offset 0x40): bit 0 sets for a tick length write, bit 1 for a reload write and bit 3 for a control write, in the same edge the value takes effect. Writing 1 to a bit clears it; a set in the same edge wins over the clear.
- R4: With the tick run bit (control bit 0) set, a tick occurs once every L+1 clocks, where L is the tick length. Setting the bit from 0 restarts the prescaler at zero, so the first tick comes L+1 edges after the control write takes effect.
- R5: Setting the counter run bit (control bit 1) from 0 loads the counter from the reload value. The counter expires on the N-th tick after that and sets interrupt status bit 0 (offset 0x30). A reload value of 0 behaves as 1.
- R6: A write to offset 0x08 changes the reload value (bits 30:0) only when bit 31 of the written data is 1; otherwise the stored value is kept.
- R7: With repeat mode (control bit 2) set, the counter reloads on each expiry and expires again every N·(L+1) clocks.
- R8: Without repeat mode, the counter halts after one expiry and raises no further interrupt until control bit 1 is cleared and set again.
- R9: While either run bit is clear the interrupt counter holds its value. Setting only the tick run bit again resumes the count without a reload.
- R10: Writing 1 to status bit 0 clears it, and an expiry in the same edge wins over the clear. `irqOut` is high exactly when the status bit and the enable bit (offset 0x34, bit 0) are both 1. Status still sets while the enable is 0.
- R11: Reads return the tick length at 0x00, the reload value at 0x08, control bits 2:0 at 0x20, status at 0x30, enable at 0x34 and write-done at 0x40. Any other offset reads 0. Status, enable and write-done writes act at the edge that samples them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, counted by the prescaler |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one write per cycle |
| busAddr | input | 8 | Byte offset of the register accessed |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Interrupt request, status AND enable |

## Verification
The embedded properties assume that reset is applied before the first meaningful clock and that the port carries at most one write per cycle. They also assume that write-done bits are never cleared in the very edge their own write completes. The bench holds to this by issuing each write through a task that lasts one full cycle, and by clearing write-done bits only after the completing edge has passed. The run bits are moved only from idle or from a settled state, so each restart comes from a known starting point, and the reference model predicts the interrupt edges exactly.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;

  // register offsets (byte addresses inside the channel)
  localparam int OFF_TICKLEN = 'h00;
  localparam int OFF_RELOAD  = 'h08;
  localparam int OFF_CTRL    = 'h20;
  localparam int OFF_STATUS  = 'h30;
  localparam int OFF_ENABLE  = 'h34;
  localparam int OFF_WDONE   = 'h40;

  // control word bit positions
  localparam int CTL_TICK_RUN = 0;
  localparam int CTL_CNT_RUN  = 1;
  localparam int CTL_REPEAT   = 2;
  localparam int CTL_W        = 3;

  // write-done bit positions
  localparam int WD_TICKLEN = 0;
  localparam int WD_RELOAD  = 1;
  localparam int WD_CTRL    = 3;
  localparam int WD_W       = 4;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic tickLoad;    // tick run bit rises this edge
    logic cntLoad;     // counter run bit rises this edge
    logic tickRun;     // current tick run level
    logic cntRun;      // current counter run level
    logic repeatMode;  // current repeat mode level
  } dpCtl_t;

endpackage

// File: rtl/tick_timer_datapath.sv
`timescale 1ns/1ps
module tick_timer_datapath
  import tick_timer_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int CNT_W  = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [TICK_W-1:0] tickLimit,
  input  logic [CNT_W-1:0]  cntReload,
  output logic              expirePulse
);

  logic [TICK_W-1:0] preCnt;
  logic [CNT_W-1:0]  intCnt;
  logic              armed;
  logic              tickPulse;
  logic              lastCount;

  // a tick ends when the prescaler reaches the limit; >= guards a shrunk limit
  assign tickPulse   = dpCtl.tickRun && (preCnt >= tickLimit);
  assign lastCount   = (intCnt <= CNT_W'(1));
  assign expirePulse = dpCtl.cntRun && armed && tickPulse && lastCount;

  // prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (dpCtl.tickLoad) begin
      preCnt <= '0;
    end else if (dpCtl.tickRun) begin
      preCnt <= tickPulse ? '0 : preCnt + TICK_W'(1);
    end
  end

  // interrupt down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intCnt <= '0;
      armed  <= 1'b0;
    end else if (dpCtl.cntLoad) begin
      intCnt <= cntReload;
      armed  <= 1'b1;
    end else if (expirePulse) begin
      intCnt <= cntReload;
      if (!dpCtl.repeatMode) armed <= 1'b0;
    end else if (dpCtl.cntRun && armed && tickPulse) begin
      intCnt <= intCnt - CNT_W'(1);
    end
  end

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (tickPulse && !dpCtl.tickLoad) |=> (preCnt == '0)); // R4

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (expirePulse && !dpCtl.repeatMode) |=> !expirePulse); // R8

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    (expirePulse && !dpCtl.repeatMode && !dpCtl.cntLoad) |=> !armed); // R8

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtl.cntRun && !dpCtl.cntLoad) |=> $stable(intCnt)); // R9

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtl.tickRun && !dpCtl.tickLoad) |=> $stable(preCnt)); // R9

endmodule

// File: rtl/tick_timer_ctrl.sv
`timescale 1ns/1ps
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int CNT_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              expirePulse,
  output dpCtl_t            dpCtl,
  output logic [DATA_W-1:0] tickLimit,
  output logic [CNT_W-1:0]  cntReload,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);

  localparam logic [ADDR_W-1:0] A_TICKLEN = ADDR_W'(OFF_TICKLEN);
  localparam logic [ADDR_W-1:0] A_RELOAD  = ADDR_W'(OFF_RELOAD);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_WDONE   = ADDR_W'(OFF_WDONE);
  localparam int UPD_BIT = DATA_W - 1;

  logic [DATA_W-1:0] tickBuf;
  logic [CNT_W-1:0]  intBuf;
  logic [CTL_W-1:0]  ctrlReg;
  logic              intStat;
  logic              intEn;
  logic [WD_W-1:0]   wDone;

  // one-stage write pipeline for the buffered registers
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;

  logic bufferedHit;
  logic applyTick, applyReload, applyCtrl;
  logic [CTL_W-1:0] newCtrl;
  logic [WD_W-1:0]  wdSet, wdClr;

  assign bufferedHit = (busAddr == A_TICKLEN) || (busAddr == A_RELOAD) || (busAddr == A_CTRL);
  assign applyTick   = pendValid && (pendAddr == A_TICKLEN);
  assign applyReload = pendValid && (pendAddr == A_RELOAD);
  assign applyCtrl   = pendValid && (pendAddr == A_CTRL);
  assign newCtrl     = pendData[CTL_W-1:0];

  always_comb begin
    wdSet = '0;
    wdSet[WD_TICKLEN] = applyTick;
    wdSet[WD_RELOAD]  = applyReload;
    wdSet[WD_CTRL]    = applyCtrl;
    wdClr = (busWrEn && busAddr == A_WDONE) ? busWrData[WD_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
    end else begin
      pendValid <= busWrEn && bufferedHit;
      pendAddr  <= busAddr;
      pendData  <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickBuf <= '0;
      intBuf  <= '0;
      ctrlReg <= '0;
    end else begin
      if (applyTick) tickBuf <= pendData;
      if (applyReload && pendData[UPD_BIT]) intBuf <= pendData[CNT_W-1:0];
      if (applyCtrl) ctrlReg <= newCtrl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wDone   <= '0;
      intStat <= 1'b0;
      intEn   <= 1'b0;
    end else begin
      wDone <= (wDone & ~wdClr) | wdSet;
      if (expirePulse) intStat <= 1'b1;
      else if (busWrEn && busAddr == A_STATUS && busWrData[0]) intStat <= 1'b0;
      if (busWrEn && busAddr == A_ENABLE) intEn <= busWrData[0];
    end
  end

  // strobes towards the datapath
  always_comb begin
    dpCtl.tickLoad   = applyCtrl && newCtrl[CTL_TICK_RUN] && !ctrlReg[CTL_TICK_RUN];
    dpCtl.cntLoad    = applyCtrl && newCtrl[CTL_CNT_RUN] && !ctrlReg[CTL_CNT_RUN];
    dpCtl.tickRun    = ctrlReg[CTL_TICK_RUN];
    dpCtl.cntRun     = ctrlReg[CTL_CNT_RUN];
    dpCtl.repeatMode = ctrlReg[CTL_REPEAT];
  end

  assign tickLimit = tickBuf;
  assign cntReload = intBuf;
  assign irqOut    = intStat && intEn;

  always_comb begin
    busRdData = '0;
    case (busAddr)
      A_TICKLEN: busRdData = tickBuf;
      A_RELOAD:  busRdData = {1'b0, intBuf};
      A_CTRL:    busRdData = DATA_W'(ctrlReg);
      A_STATUS:  busRdData = DATA_W'(intStat);
      A_ENABLE:  busRdData = DATA_W'(intEn);
      A_WDONE:   busRdData = DATA_W'(wDone);
      default:   busRdData = '0;
    endcase
  end

  AST_CTRL_WDONE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_CTRL) |=> ##1 wDone[WD_CTRL]); // R3

  AST_TICK_WDONE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_TICKLEN) |=> ##1 (wDone[WD_TICKLEN] && tickBuf == $past(busWrData, 2))); // R2

  AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_RELOAD && !busWrData[UPD_BIT]) |=> ##1 $stable(intBuf)); // R6

  AST_STATUS_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |=> intStat); // R10

  AST_RESERVED_DONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    !wDone[2]); // R3

endmodule

// File: rtl/tick_timer_channel.sv
`timescale 1ns/1ps
module tick_timer_channel
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int CNT_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);

  dpCtl_t            dpCtl;
  logic [DATA_W-1:0] tickLimit;
  logic [CNT_W-1:0]  cntReload;
  logic              expirePulse;

  tick_timer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .expirePulse(expirePulse), .dpCtl(dpCtl),
    .tickLimit(tickLimit), .cntReload(cntReload),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  tick_timer_datapath #(.TICK_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl),
    .tickLimit(tickLimit), .cntReload(cntReload),
    .expirePulse(expirePulse)
  );

endmodule

// File: tb/tick_timer_channel_tb_top.sv
`timescale 1ns/1ps
module tick_timer_channel_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;

  always #2.5 clk = ~clk;  // 200 MHz

  tick_timer_channel dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut)
  );

  int    checkCnt = 0;
  int    failCnt = 0;
  bit    reported = 0;
  string phase = "R1";

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    end
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mTick, mPre, mPendD;
  logic [30:0] mReload, mCnt;
  logic [2:0]  mCtrl;
  logic [3:0]  mDone;
  logic        mStat, mEn, mArmed, mPendV;
  logic [7:0]  mPendA;
  int          edgeNo = 0;
  int          riseQ[$];
  logic        prevIrq = 1'b0;

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    case (a)
      8'h00: return mTick;
      8'h08: return {1'b0, mReload};
      8'h20: return {29'd0, mCtrl};
      8'h30: return {31'd0, mStat};
      8'h34: return {31'd0, mEn};
      8'h40: return {28'd0, mDone};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTick = 0; mPre = 0; mPendD = 0; mReload = 0; mCnt = 0; mCtrl = 0;
      mDone = 0; mStat = 0; mEn = 0; mArmed = 0; mPendV = 0; mPendA = 0;
    end else begin
      bit tick, expire, riseT, riseC;
      bit [2:0] nc;
      nc     = mPendD[2:0];
      riseT  = mPendV && mPendA == 8'h20 && nc[0] && !mCtrl[0];
      riseC  = mPendV && mPendA == 8'h20 && nc[1] && !mCtrl[1];
      tick   = mCtrl[0] && (mPre >= mTick);
      expire = mCtrl[1] && mArmed && tick && (mCnt <= 1);
      if (riseT) mPre = 0;
      else if (mCtrl[0]) mPre = tick ? 0 : mPre + 1;
      if (riseC) begin mCnt = mReload; mArmed = 1; end
      else if (expire) begin mCnt = mReload; if (!mCtrl[2]) mArmed = 0; end
      else if (mCtrl[1] && mArmed && tick) mCnt = mCnt - 1;
      if (expire) mStat = 1;
      else if (busWrEn && busAddr == 8'h30 && busWrData[0]) mStat = 0;
      if (busWrEn && busAddr == 8'h34) mEn = busWrData[0];
      if (busWrEn && busAddr == 8'h40) mDone = mDone & ~busWrData[3:0];
      if (mPendV) begin
        case (mPendA)
          8'h00: begin mTick = mPendD; mDone[0] = 1; end
          8'h08: begin if (mPendD[31]) mReload = mPendD[30:0]; mDone[1] = 1; end
          default: begin mCtrl = nc; mDone[3] = 1; end
        endcase
      end
      mPendV = busWrEn && (busAddr == 8'h00 || busAddr == 8'h08 || busAddr == 8'h20);
      mPendA = busAddr;
      mPendD = busWrData;
    end
    edgeNo++;
    #1;
    chk(irqOut === (mStat & mEn), {phase, " irqOut vs model"}, irqOut, mStat & mEn);
    chk(busRdData === modelRead(busAddr), {phase, " R11 readback vs model"}, busRdData, modelRead(busAddr));
    if (irqOut && !prevIrq) riseQ.push_back(edgeNo);
    prevIrq = irqOut;
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdCheck(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a;
    #1;
    chk(busRdData === exp, tag, busRdData, exp);
  endtask

  // write control and count edges until irqOut rises
  task automatic measure(input logic [31:0] ctl, input int exp, input string tag);
    int n = 0;
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 8'h20; busWrData = ctl;
    while (n < 1000) begin
      @(posedge clk); #1; n++;
      if (irqOut) break;
      if (n == 1) begin @(negedge clk); busWrEn = 1'b0; end
    end
    @(negedge clk);
    busWrEn = 1'b0;
    chk(n == exp, tag, n, exp);
  endtask

  task automatic waitRises(input int k);
    while (riseQ.size() < k) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rdCheck(8'h00, 0, "R1 tick length"); rdCheck(8'h08, 0, "R1 reload");
    rdCheck(8'h20, 0, "R1 control");     rdCheck(8'h40, 0, "R1 write-done");
    chk(irqOut === 1'b0, "R1 irqOut", irqOut, 0);

    // R3 write-done bits
    phase = "R3";
    wr(8'h00, 1); wr(8'h08, 32'h8000_0003); wr(8'h34, 1);
    @(negedge clk);
    rdCheck(8'h40, 32'h3, "R3 done bits after two writes");
    wr(8'h40, 1);
    rdCheck(8'h40, 32'h2, "R3 clear bit0 only");
    wr(8'h40, 2);
    rdCheck(8'h40, 32'h0, "R3 clear bit1");

    // R2 latency
    phase = "R2";
    @(negedge clk);
    busWrEn = 1; busAddr = 8'h00; busWrData = 5;
    @(negedge clk);
    busWrEn = 0; #1;
    chk(busRdData === 1, "R2 old value after first edge", busRdData, 1);
    @(negedge clk); #1;
    chk(busRdData === 5, "R2 new value after second edge", busRdData, 5);
    wr(8'h00, 1); @(negedge clk); wr(8'h40, 1);

    // R6 reload update bit
    phase = "R6";
    wr(8'h08, 7); @(negedge clk);
    rdCheck(8'h08, 3, "R6 reload kept without bit31");
    wr(8'h40, 2);

    // R4/R5 first expiry: L=1, N=3 -> 2 + 3*2 edges
    phase = "R4";
    riseQ.delete();
    measure(32'h7, 8, "R4 R5 first interrupt edge");

    // R7 repeat period 6
    phase = "R7";
    wr(8'h30, 1); waitRises(2);
    wr(8'h30, 1); waitRises(3);
    chk(riseQ[1] - riseQ[0] == 6, "R7 repeat period", riseQ[1] - riseQ[0], 6);
    chk(riseQ[2] - riseQ[1] == 6, "R7 repeat period again", riseQ[2] - riseQ[1], 6);

    // R9 freeze while tick run clear, resume without reload
    phase = "R9";
    wr(8'h20, 32'h6); wr(8'h30, 1);
    repeat (40) @(negedge clk);
    chk(irqOut === 1'b0, "R9 no interrupt while ticks stopped", irqOut, 0);
    wr(8'h20, 32'h7);
    repeat (30) @(negedge clk);
    wr(8'h20, 0); wr(8'h30, 1);

    // R8 one-shot: L=1, N=2 -> 2 + 2*2 edges
    phase = "R8";
    wr(8'h08, 32'h8000_0002); @(negedge clk);
    measure(32'h3, 6, "R8 one-shot first interrupt");
    wr(8'h30, 1);
    repeat (40) @(negedge clk);
    chk(irqOut === 1'b0, "R8 no second interrupt", irqOut, 0);
    rdCheck(8'h30, 0, "R8 status stays clear");

    // R5 reload 0 acts as 1, L=0 -> 2 + 1 edges
    phase = "R5";
    wr(8'h20, 0); wr(8'h00, 0); wr(8'h08, 32'h8000_0000); @(negedge clk);
    measure(32'h3, 3, "R5 zero reload expires on first tick");

    // R10 enable gating
    phase = "R10";
    wr(8'h30, 1); wr(8'h34, 0); wr(8'h20, 0);
    wr(8'h20, 32'h3);
    repeat (20) @(negedge clk);
    chk(irqOut === 1'b0, "R10 masked interrupt", irqOut, 0);
    rdCheck(8'h30, 1, "R10 status set while masked");
    wr(8'h34, 1); #1;
    chk(irqOut === 1'b1, "R10 unmasked interrupt", irqOut, 1);

    // R11 read map
    phase = "R11";
    rdCheck(8'h20, 3, "R11 control readback");
    rdCheck(8'h34, 1, "R11 enable readback");
    rdCheck(8'h08, 0, "R11 reload readback");
    rdCheck(8'h3C, 0, "R11 unmapped offset");
    repeat (5) @(negedge clk);
    report();
  end

endmodule